// File: doc/BRIEF.md
# Four-Channel DMA Engine with Per-Channel Word Mode

This block moves data between memory and up to four peripherals without the host processor touching each item. A host writes each channel's start address, transfer count, service mode and mask through a small register port. A channel becomes eligible when it is unmasked and either its request pin or its software request bit is set. The engine then raises a bus request and waits for the grant. Once granted, it drives the memory address, byte enables and paired memory/peripheral strobes, and it acknowledges the peripheral it is serving.

Each channel is set to byte or 16-bit word transfers on its own. A zero-wait transfer takes two clocks. A word-mode channel therefore moves twice the bytes per clock of a byte-mode channel. A channel can also copy one memory range to another, reading at its current address and writing at a destination address. In a fill variant the source address is held, so one value is written across the whole destination range. The last transfer flags end of process. The channel then either reloads its start values or masks itself.

Top module: `dma4w`

## Requirements
- R1: After reset, hold_o, dack_o, eop_o and all four strobes are 0. All mask bits read 1 at global address 16. Every channel field reads 0.
- R2: Channel register address is {1'b0, channel[1:0], field[1:0]}. Fields: 0 = current address (a write also sets the base address), 1 = current count (a write also sets the base count), 2 = destination address, 3 = mode (bits 7:0 stored, bits 15:8 read 0). Address 16 reads and writes the mask bits [3:0]. Address 17 reads and writes the software request bits [3:0].
- R3: A count of N performs N+1 transfers. eop_o is high during the strobe of the last transfer. Without reload, the count then reads 16'hFFFF.
- R4: At end of process, a channel with mode bit 2 (reload) set restores its address and count from the base values and keeps its mask clear. Without reload, its mask bit is set.
- R5: After each transfer the address steps by 1 in byte mode and by 2 in word mode (mode bit 4). Mode bit 3 makes the step a decrement. The address wraps modulo 2^16.
- R6: be_o is 2'b11 in word mode. In byte mode it is 2'b01 for an even address and 2'b10 for an odd address.
- R7: Among unmasked requesting channels, the lowest-numbered channel is served first. A masked channel is never acknowledged.
- R8: Mode bits 1:0 = 0 (single): hold_o drops after every transfer, and the bus is requested again for the next one.
- R9: Mode bits 1:0 = 1 (block): the channel keeps the bus until end of process, with one transfer strobe every 2 clocks.
- R10: Mode bits 1:0 = 2 (demand): transfers continue while the request stays high. When the request drops, the bus is released with the remaining count and address kept, and a later request resumes from there.
- R11: With mode bit 5 set, a transfer drives mem_rd_o and io_wr_o; with it clear, io_rd_o and mem_wr_o. dack_o is set only for the serviced channel.
- R12: Setting a channel's software request bit starts service without its request pin. The bit clears at end of process.
- R13: With mode bit 6 set, each unit reads memory at the current address and writes that data at the destination address; both addresses step. With mode bit 7 also set, the source address is held. dack_o stays 0 in this mode.
- R14: No strobe is driven before hlda_i is high. hold_o stays high while the grant is withheld.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 5 | Register address |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data, combinational from address |
| dreq_i | input | 4 | Per-channel peripheral request |
| dack_o | output | 4 | Per-channel acknowledge |
| hold_o | output | 1 | Bus request to host |
| hlda_i | input | 1 | Bus grant from host |
| addr_o | output | 16 | Memory address |
| be_o | output | 2 | Byte enables |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| io_rd_o | output | 1 | Peripheral read strobe |
| io_wr_o | output | 1 | Peripheral write strobe |
| mem_rdata_i | input | 16 | Memory read data (copy mode) |
| mem_wdata_o | output | 16 | Memory write data (copy mode) |
| eop_o | output | 1 | End of process |

## Verification
Block transfers are tried on all four channels with these pattern pairs:
- byte and word mode, which tells 1-step from 2-step addressing and the byte-enable choice apart;
- incrementing and decrementing addresses, plus a start just below the top of the range, which exposes a missing wrap;
- counts of zero and above, which separate off-by-one terminal detection;
- reload and mask-on-finish endings, which are checked by reading the registers back.

Further tests target the other behaviours:
- simultaneous requests with a masked channel, for fixed priority;
- single mode against demand mode with a dropped request, which tells bus release per transfer from release on request loss;
- software-only requests;
- copy against fill, which shows whether the source address steps;
- a withheld grant, which must suppress every strobe.

// File: rtl/dma4w_pkg.sv
package dma4w_pkg;
  typedef enum logic [1:0] {
    SVC_SINGLE = 2'd0,
    SVC_BLOCK  = 2'd1,
    SVC_DEMAND = 2'd2,
    SVC_RSVD   = 2'd3
  } svc_e;

  typedef struct packed {
    logic fill;
    logic m2m;
    logic rd_mem;
    logic word;
    logic dec;
    logic autoi;
    svc_e svc;
  } mode_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_REQ, ST_RA, ST_RB, ST_WA, ST_WB
  } st_e;
endpackage

// File: rtl/dma4w_chan.sv
module dma4w_chan
  import dma4w_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [1:0]    fld_i,
  input  logic [AW-1:0] wdata_i,
  input  logic          msk_we_i,
  input  logic          msk_d_i,
  input  logic          srq_we_i,
  input  logic          srq_d_i,
  input  logic          step_src_i,
  input  logic          step_dst_i,
  input  logic          xfer_i,
  input  logic          tc_i,
  output logic [AW-1:0] cur_o,
  output logic [AW-1:0] cnt_o,
  output logic [AW-1:0] dst_o,
  output mode_t         mode_o,
  output logic          mask_o,
  output logic          sreq_o
);
  logic [AW-1:0] base_a, cur_a, base_c, cur_c, dst_a;
  logic [AW-1:0] delta, nxt_src, nxt_dst;
  mode_t mode_q;
  logic  mask_q, sreq_q;

  assign delta   = mode_q.word ? AW'(2) : AW'(1);
  assign nxt_src = mode_q.dec ? cur_a - delta : cur_a + delta;
  assign nxt_dst = mode_q.dec ? dst_a - delta : dst_a + delta;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_a <= '0;
      cur_a  <= '0;
      base_c <= '0;
      cur_c  <= '0;
      dst_a  <= '0;
      mode_q <= '0;
      mask_q <= 1'b1;
      sreq_q <= 1'b0;
    end else begin
      if (step_src_i) cur_a <= nxt_src;
      if (step_dst_i) dst_a <= nxt_dst;
      if (xfer_i)     cur_c <= cur_c - AW'(1);
      if (tc_i) begin
        sreq_q <= 1'b0;
        if (mode_q.autoi) begin
          cur_a <= base_a;
          cur_c <= base_c;
        end else begin
          mask_q <= 1'b1;
        end
      end
      if (msk_we_i) mask_q <= msk_d_i;
      if (srq_we_i) sreq_q <= srq_d_i;
      if (wr_i) begin
        case (fld_i)
          2'd0: begin base_a <= wdata_i; cur_a <= wdata_i; end
          2'd1: begin base_c <= wdata_i; cur_c <= wdata_i; end
          2'd2: dst_a  <= wdata_i;
          default: mode_q <= mode_t'(wdata_i[7:0]);
        endcase
      end
    end
  end

  assign cur_o  = cur_a;
  assign cnt_o  = cur_c;
  assign dst_o  = dst_a;
  assign mode_o = mode_q;
  assign mask_o = mask_q;
  assign sreq_o = sreq_q;

  AST_TC_ON_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_i && cur_c == '0) |-> tc_i); // R3
  AST_ADDR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_src_i && !tc_i && !wr_i) |=> (cur_a == $past(nxt_src))); // R5
  AST_TC_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tc_i && !mode_q.autoi && !msk_we_i) |=> mask_o); // R4
  AST_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tc_i && mode_q.autoi && !wr_i) |=> (cur_c == $past(base_c))); // R4
endmodule

// File: rtl/dma4w_arb.sv
module dma4w_arb #(
  parameter int NCH = 4,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [NCH-1:0] req_i,
  output logic           vld_o,
  output logic [CW-1:0]  idx_o
);
  // fixed priority, lowest index wins
  always_comb begin
    idx_o = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = CW'(i);
    end
  end
  assign vld_o = |req_i;
endmodule

// File: rtl/dma4w.sv
module dma4w
  import dma4w_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 16,
  parameter int DW  = 16,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [CW+2:0] reg_addr_i,
  input  logic [AW-1:0] reg_wdata_i,
  output logic [AW-1:0] reg_rdata_o,
  input  logic [NCH-1:0] dreq_i,
  output logic [NCH-1:0] dack_o,
  output logic          hold_o,
  input  logic          hlda_i,
  output logic [AW-1:0] addr_o,
  output logic [1:0]    be_o,
  output logic          mem_rd_o,
  output logic          mem_wr_o,
  output logic          io_rd_o,
  output logic          io_wr_o,
  input  logic [DW-1:0] mem_rdata_i,
  output logic [DW-1:0] mem_wdata_o,
  output logic          eop_o
);
  logic          glob;
  logic [CW-1:0] chs;
  logic [1:0]    fld;
  assign glob = reg_addr_i[CW+2];
  assign chs  = reg_addr_i[CW+1:2];
  assign fld  = reg_addr_i[1:0];

  logic [AW-1:0] cur_w [NCH];
  logic [AW-1:0] cnt_w [NCH];
  logic [AW-1:0] dst_w [NCH];
  mode_t         mode_w [NCH];
  logic [NCH-1:0] mask_v, sreq_v, pend;

  st_e           st_q, st_d, nxt_unit;
  logic [CW-1:0] ch_q, arb_idx;
  logic          arb_vld;
  logic [DW-1:0] dat_q;
  mode_t         cm;
  logic          unit_end, last, peri, in_wr;

  assign cm       = mode_w[ch_q];
  assign peri     = !cm.m2m;
  assign last     = (cnt_w[ch_q] == '0);
  assign unit_end = (st_q == ST_RB && peri) || st_q == ST_WB;
  assign in_wr    = (st_q == ST_WA) || (st_q == ST_WB);
  assign pend     = ~mask_v & (dreq_i | sreq_v);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic sel;
    assign sel = (ch_q == CW'(i));
    dma4w_chan #(.AW(AW)) u_chan (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_i       (reg_we_i && !glob && chs == CW'(i)),
      .fld_i      (fld),
      .wdata_i    (reg_wdata_i),
      .msk_we_i   (reg_we_i && glob && fld == 2'd0),
      .msk_d_i    (reg_wdata_i[i]),
      .srq_we_i   (reg_we_i && glob && fld == 2'd1),
      .srq_d_i    (reg_wdata_i[i]),
      .step_src_i (sel && st_q == ST_RB && !(cm.m2m && cm.fill)),
      .step_dst_i (sel && st_q == ST_WB),
      .xfer_i     (sel && unit_end),
      .tc_i       (sel && unit_end && last),
      .cur_o      (cur_w[i]),
      .cnt_o      (cnt_w[i]),
      .dst_o      (dst_w[i]),
      .mode_o     (mode_w[i]),
      .mask_o     (mask_v[i]),
      .sreq_o     (sreq_v[i])
    );
    assign dack_o[i] = sel && peri && (st_q == ST_RA || st_q == ST_RB);
  end

  dma4w_arb #(.NCH(NCH)) u_arb (
    .req_i (pend),
    .vld_o (arb_vld),
    .idx_o (arb_idx)
  );

  always_comb begin
    if (glob) begin
      case (fld)
        2'd0:    reg_rdata_o = AW'(mask_v);
        2'd1:    reg_rdata_o = AW'(sreq_v);
        default: reg_rdata_o = '0;
      endcase
    end else begin
      case (fld)
        2'd0:    reg_rdata_o = cur_w[chs];
        2'd1:    reg_rdata_o = cnt_w[chs];
        2'd2:    reg_rdata_o = dst_w[chs];
        default: reg_rdata_o = AW'(mode_w[chs]);
      endcase
    end
  end

  // decision at the end of one transfer unit
  always_comb begin
    if (last)                                          nxt_unit = ST_IDLE;
    else if (cm.m2m || cm.svc == SVC_BLOCK || cm.svc == SVC_RSVD) nxt_unit = ST_RA;
    else if (cm.svc == SVC_DEMAND && pend[ch_q])       nxt_unit = ST_RA;
    else                                               nxt_unit = ST_IDLE;
  end

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE: if (arb_vld) st_d = ST_REQ;
      ST_REQ:  if (hlda_i)  st_d = ST_RA;
      ST_RA:   st_d = ST_RB;
      ST_RB:   st_d = cm.m2m ? ST_WA : nxt_unit;
      ST_WA:   st_d = ST_WB;
      ST_WB:   st_d = nxt_unit;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      ch_q  <= '0;
      dat_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_IDLE && arb_vld) ch_q <= arb_idx;
      if (st_q == ST_RB && cm.m2m)    dat_q <= mem_rdata_i;
    end
  end

  assign hold_o      = (st_q != ST_IDLE);
  assign addr_o      = in_wr ? dst_w[ch_q] : cur_w[ch_q];
  assign be_o        = cm.word ? 2'b11 : (addr_o[0] ? 2'b10 : 2'b01);
  assign mem_rd_o    = (st_q == ST_RB) && (cm.m2m || cm.rd_mem);
  assign mem_wr_o    = ((st_q == ST_RB) && peri && !cm.rd_mem) || (st_q == ST_WB);
  assign io_rd_o     = (st_q == ST_RB) && peri && !cm.rd_mem;
  assign io_wr_o     = (st_q == ST_RB) && peri && cm.rd_mem;
  assign mem_wdata_o = dat_q;
  assign eop_o       = unit_end && last;

  AST_STROBE_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rd_o || mem_wr_o || io_rd_o || io_wr_o) |-> hlda_i); // R14
  AST_EOP_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eop_o && !cm.autoi && !reg_we_i) |=> mask_v[ch_q]); // R4
  AST_PRIO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && arb_vld) |=>
      (($past(pend) & ((NCH'(1) << ch_q) - NCH'(1))) == '0)); // R7
  AST_SINGLE_REL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unit_end && peri && cm.svc == SVC_SINGLE) |=> !hold_o); // R8
endmodule

// File: tb/dma4w_test.sv
module dma4w_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [4:0]  ra = '0;
  logic [15:0] wd = '0, rdata;
  logic [3:0]  dreq = '0, dack;
  logic        hold, hlda, hlda_q, hlda_en = 1'b1;
  logic [15:0] addr, mrd, mwd;
  logic [1:0]  be;
  logic        mem_rd, mem_wr, io_rd, io_wr, eop;

  always #10 clk = ~clk;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) hlda_q <= 1'b0; else hlda_q <= hold;
  assign hlda = hlda_q & hlda_en;
  assign mrd  = addr ^ 16'h5A5A;

  dma4w uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(ra),
    .reg_wdata_i(wd), .reg_rdata_o(rdata), .dreq_i(dreq), .dack_o(dack),
    .hold_o(hold), .hlda_i(hlda), .addr_o(addr), .be_o(be),
    .mem_rd_o(mem_rd), .mem_wr_o(mem_wr), .io_rd_o(io_rd), .io_wr_o(io_wr),
    .mem_rdata_i(mrd), .mem_wdata_o(mwd), .eop_o(eop));

  int checks = 0, fails = 0, cyc = 0;
  int n_x, n_eop, n_hold, n_w, bad_w, gmin, gmax, last_cyc;
  logic [15:0] last_a, eop_a, rd_a, last_wa, last_wd;
  logic [1:0]  last_be;
  logic [3:0]  last_dack, first_dack, or_dack, last_str;
  logic        hold_p = 1'b0;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog act=%0d exp=<150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (hold && !hold_p) n_hold++;
    hold_p = hold;
    if (io_rd || io_wr) begin
      if (n_x > 0) begin
        if (cyc - last_cyc < gmin) gmin = cyc - last_cyc;
        if (cyc - last_cyc > gmax) gmax = cyc - last_cyc;
      end else first_dack = dack;
      last_cyc  = cyc;
      n_x++;
      last_a    = addr;
      last_be   = be;
      last_dack = dack;
      or_dack   = or_dack | dack;
      last_str  = {mem_rd, mem_wr, io_rd, io_wr};
    end
    if (mem_rd && dack == 4'b0) rd_a = addr;
    if (mem_wr && dack == 4'b0) begin
      n_w++;
      last_wa = addr;
      last_wd = mwd;
      if (mwd !== (rd_a ^ 16'h5A5A)) bad_w++;
    end
    if (eop) begin n_eop++; eop_a = addr; end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic clr();
    n_x = 0; n_eop = 0; n_hold = 0; n_w = 0; bad_w = 0;
    gmin = 9999; gmax = 0; or_dack = '0; first_dack = '0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk); we = 1'b1; ra = a; wd = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] d);
    @(negedge clk); ra = a; #1 d = rdata;
  endtask

  task automatic prog(input logic [1:0] ch, input logic [7:0] m,
                      input logic [15:0] a, input logic [15:0] c);
    wr({1'b0, ch, 2'd0}, a);
    wr({1'b0, ch, 2'd1}, c);
    wr({1'b0, ch, 2'd3}, {8'h00, m});
  endtask

  task automatic wait_eop(input int n);
    int t = 0;
    while (n_eop < n && t < 5000) begin @(posedge clk); t++; end
    @(negedge clk);
  endtask

  // {ch, mode, start address, count}
  localparam logic [41:0] VEC [6] = '{
    {2'd0, 8'h01, 16'h1000, 16'd3},
    {2'd1, 8'h31, 16'h2000, 16'd2},
    {2'd2, 8'h09, 16'h0005, 16'd4},
    {2'd3, 8'h1D, 16'h3000, 16'd1},
    {2'd0, 8'h01, 16'hFFFE, 16'd2},
    {2'd1, 8'h25, 16'h0040, 16'd0}
  };

  initial begin
    logic [15:0] r;
    clr();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 hold", hold, 0);
    chk("R1 dack", dack, 0);
    chk("R1 strobes", {mem_rd, mem_wr, io_rd, io_wr, eop}, 0);
    rd(5'd16, r); chk("R1 mask", r, 16'h000F);
    rd(5'd0, r);  chk("R1 addr0", r, 0);
    rd(5'd15, r); chk("R1 mode3", r, 0);
    // R2 readback
    wr(5'b0_10_10, 16'hBEEF); rd(5'b0_10_10, r); chk("R2 dest", r, 16'hBEEF);
    wr(5'b0_01_11, 16'h12A5); rd(5'b0_01_11, r); chk("R2 mode", r, 16'h00A5);
    wr(5'd17, 16'h0000);      rd(5'd17, r);      chk("R2 sreq", r, 16'h0000);

    // vector table: block transfers
    foreach (VEC[v]) begin
      logic [1:0]  ch;
      logic [7:0]  m;
      logic [15:0] a, c, step, lst, fin, fc;
      logic [3:0]  bit1;
      {ch, m, a, c} = VEC[v];
      step = m[4] ? 16'd2 : 16'd1;
      lst  = m[3] ? a - step * c : a + step * c;
      fin  = m[2] ? a : (m[3] ? lst - step : lst + step);
      fc   = m[2] ? c : 16'hFFFF;
      bit1 = 4'b0001 << ch;
      wr(5'd16, 16'h000F);
      clr();
      prog(ch, m, a, c);
      dreq = bit1;
      wr(5'd16, {12'h000, ~bit1});
      wait_eop(1);
      dreq = '0;
      repeat (4) @(negedge clk);
      chk("R3 transfers", n_x, c + 1);
      chk("R3 eop at last", eop_a, lst);
      chk("R3 eop count", n_eop, 1);
      chk("R5 last addr", last_a, lst);
      chk("R6 byte enable", last_be, m[4] ? 2'b11 : (lst[0] ? 2'b10 : 2'b01));
      chk("R11 dack", last_dack, bit1);
      chk("R11 strobes", last_str, m[5] ? 4'b1001 : 4'b0110);
      if (c > 0) chk("R9 spacing", {gmin[15:0], gmax[15:0]}, {16'd2, 16'd2});
      chk("R9 released", hold, 0);
      rd({1'b0, ch, 2'd0}, r); chk("R5 final addr", r, fin);
      rd({1'b0, ch, 2'd1}, r); chk("R3 final count", r, fc);
      rd(5'd16, r); chk("R4 mask", r[ch], !m[2]);
    end

    // R7 priority, masked channel ignored
    wr(5'd16, 16'h000F);
    clr();
    prog(2'd1, 8'h01, 16'h4000, 16'd1);
    prog(2'd2, 8'h01, 16'h5000, 16'd1);
    dreq = 4'b0111;
    wr(5'd16, 16'h0009);
    wait_eop(2);
    dreq = '0;
    repeat (4) @(negedge clk);
    chk("R7 first", first_dack, 4'b0010);
    chk("R7 last", last_dack, 4'b0100);
    chk("R7 masked ignored", or_dack, 4'b0110);
    chk("R7 transfers", n_x, 4);

    // R8 single mode
    wr(5'd16, 16'h000F);
    clr();
    prog(2'd2, 8'h00, 16'h6000, 16'd2);
    dreq = 4'b0100;
    wr(5'd16, 16'h000B);
    wait_eop(1);
    dreq = '0;
    repeat (4) @(negedge clk);
    chk("R8 transfers", n_x, 3);
    chk("R8 hold rises", n_hold, 3);
    chk("R8 gap above 2", gmin > 2, 1);

    // R10 demand mode
    wr(5'd16, 16'h000F);
    clr();
    prog(2'd3, 8'h02, 16'h7000, 16'd15);
    dreq = 4'b1000;
    wr(5'd16, 16'h0007);
    begin
      int k = 0, t = 0;
      while (k < 5 && t < 5000) begin
        @(negedge clk); t++;
        if (io_rd) k++;
      end
    end
    dreq = '0;
    repeat (6) @(negedge clk);
    chk("R10 released", hold, 0);
    chk("R10 transfers", n_x, 5);
    chk("R10 no eop", n_eop, 0);
    rd(5'b0_11_01, r); chk("R10 count kept", r, 16'd10);
    rd(5'b0_11_00, r); chk("R10 addr kept", r, 16'h7005);
    rd(5'd16, r); chk("R10 unmasked", r[3], 0);
    clr();
    dreq = 4'b1000;
    wait_eop(1);
    dreq = '0;
    repeat (4) @(negedge clk);
    chk("R10 resumed", n_x, 11);
    chk("R10 resumed end", last_a, 16'h700F);

    // R12 software request
    wr(5'd16, 16'h000F);
    clr();
    prog(2'd0, 8'h01, 16'h0A00, 16'd1);
    wr(5'd16, 16'h000E);
    repeat (5) @(negedge clk);
    chk("R12 idle without request", hold, 0);
    wr(5'd17, 16'h0001);
    wait_eop(1);
    repeat (4) @(negedge clk);
    chk("R12 transfers", n_x, 2);
    rd(5'd17, r); chk("R12 sreq cleared", r, 0);

    // R13 memory copy
    wr(5'd16, 16'h000F);
    clr();
    prog(2'd1, 8'h41, 16'h0100, 16'd2);
    wr(5'b0_01_10, 16'h0800);
    wr(5'd16, 16'h000D);
    wr(5'd17, 16'h0002);
    wait_eop(1);
    repeat (4) @(negedge clk);
    chk("R13 writes", n_w, 3);
    chk("R13 data", bad_w, 0);
    chk("R13 last dst", last_wa, 16'h0802);
    chk("R13 no dack", n_x, 0);
    chk("R3 copy eop", eop_a, 16'h0802);
    rd(5'b0_01_00, r); chk("R13 src stepped", r, 16'h0103);
    rd(5'b0_01_10, r); chk("R13 dst stepped", r, 16'h0803);

    // R13 block fill
    wr(5'd16, 16'h000F);
    clr();
    prog(2'd1, 8'hC1, 16'h0200, 16'd3);
    wr(5'b0_01_10, 16'h0900);
    wr(5'd16, 16'h000D);
    wr(5'd17, 16'h0002);
    wait_eop(1);
    repeat (4) @(negedge clk);
    chk("R13 fill writes", n_w, 4);
    chk("R13 fill data", {bad_w[15:0], last_wd}, {16'd0, 16'h0200 ^ 16'h5A5A});
    rd(5'b0_01_00, r); chk("R13 fill src held", r, 16'h0200);
    rd(5'b0_01_10, r); chk("R13 fill dst", r, 16'h0904);

    // R14 grant withheld
    wr(5'd16, 16'h000F);
    clr();
    hlda_en = 1'b0;
    prog(2'd0, 8'h01, 16'h0B00, 16'd0);
    dreq = 4'b0001;
    wr(5'd16, 16'h000E);
    repeat (10) @(negedge clk);
    chk("R14 hold waiting", hold, 1);
    chk("R14 no strobe", n_x, 0);
    hlda_en = 1'b1;
    wait_eop(1);
    dreq = '0;
    repeat (4) @(negedge clk);
    chk("R14 after grant", n_x, 1);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule